// File: doc/BRIEF.md
# Lockstep Instruction-Index Sequencer

The block is the single global controller of an array of small 16-bit processing elements that run in lockstep. Each element holds its own 32-entry instruction store. The sequencer puts out one shared instruction index per cycle, and every element reads its own store at that index. One program counter therefore drives many stores, and each element can perform a different operation in the same cycle.

The host processor starts an operation with an issue command. The command carries a start index and a length. After accepting the command, the sequencer steps the index up by one every cycle. The index wraps modulo the store depth. Broadcasting stops when the requested number of indices has been sent. A busy level covers the whole operation, and a one-cycle done pulse marks the last index. A command that arrives while busy is dropped, and an error pulse reports the drop.

The array runs in lockstep and cannot hold the sequencer back. For that reason the index bus carries only a valid qualifier and has no ready. Every cycle in which `idx_valid` is high delivers exactly one index, and the array has to consume it in that cycle. The command and status pins are plain single-cycle control signals.

Top module: `nano_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `err_busy` and `idx_valid` are 0 and `idx` is 0.
- R2: If `cmd_issue` is high at a clock edge while `busy` is 0, then in the next cycle `busy` and `idx_valid` are 1 and `idx` equals `cmd_start`.
- R3: During each further cycle of an operation, `idx` is one more than in the previous cycle, modulo 32, so index 31 is followed by index 0.
- R4: An operation puts out exactly `cmd_len` indices. A `cmd_len` of 0 means 32 indices.
- R5: `done` is 1 only in the cycle that carries the last index of an operation. In the cycle after that, `busy`, `idx_valid` and `done` are all 0.
- R6: If `cmd_issue` is high at a clock edge while `busy` is 1, the command is ignored. This includes the cycle in which `done` is high. The index sequence in progress continues unchanged, and `err_busy` is 1 for exactly the next cycle.
- R7: A command issued in the first cycle after `done` is accepted, so consecutive operations are separated by a single idle cycle.
- R8: In each broadcast cycle, every element's local store is read at the same `idx`, so the elements fetch different words during the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_issue | input | 1 | Host issue strobe |
| cmd_start | input | 5 | First instruction index of the operation |
| cmd_len | input | 5 | Number of indices to send; 0 means 32 |
| busy | output | 1 | High from the cycle after acceptance through the last index |
| done | output | 1 | One-cycle pulse that comes with the last index |
| err_busy | output | 1 | One-cycle pulse after a command was dropped because the block was busy |
| idx_valid | output | 1 | The broadcast index is valid in this cycle |
| idx | output | 5 | Shared instruction index sent to all elements |

## Verification
The main function is driven by a table of start and length pairs. A run that begins at 0 with a short length checks plain counting. Runs that begin near 31 can only pass if the index wraps modulo 32 rather than stopping or saturating. Lengths of 1, 31 and 0 separate an off-by-one error in the length counter from the correct case, and length 0 in particular must give 32 indices rather than none or one. Directed tests then issue a command in the middle of a run, in the done cycle and in the first idle cycle. These tests separate a dropped command from a restarted run and show that a new operation can start without a lost cycle. Four modelled element stores with different contents confirm that all elements fetch at the same shared index.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  function automatic int unsigned depth_of(input int unsigned w);
    return 32'd1 << w;
  endfunction
endpackage

// File: rtl/seq_issue_gate.sv
module seq_issue_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_issue,
  input  logic busy,
  output logic accept,
  output logic err_pulse
);
  logic err_q;

  assign accept = cmd_issue & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= cmd_issue & busy;
  end

  assign err_pulse = err_q;
endmodule

// File: rtl/seq_len_ctr.sv
module seq_len_ctr #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             busy,
  output logic             last
);
  import nseq_pkg::*;

  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(depth_of(LEN_W) - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    if (cmd_len == '0) load_val = FULL_M1;
    else               load_val = {1'b0, cmd_len} - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      rem_q <= '0;
    end else if (accept) begin
      ph_q  <= PH_RUN;
      rem_q <= load_val;
    end else if (ph_q == PH_RUN) begin
      if (rem_q == '0) ph_q <= PH_IDLE;
      else             rem_q <= rem_q - CNT_W'(1);
    end
  end

  assign busy = (ph_q == PH_RUN);
  assign last = busy && (rem_q == '0);
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [IDX_W-1:0] start,
  input  logic             advance,
  output logic [IDX_W-1:0] pc
);
  logic [IDX_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= '0;
    else if (accept)  pc_q <= start;
    else if (advance) pc_q <= pc_q + IDX_W'(1);
  end

  assign pc = pc_q;
endmodule

// File: rtl/nano_seq_ctrl.sv
module nano_seq_ctrl #(
  parameter int IDX_W = 5,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_issue,
  input  logic [IDX_W-1:0] cmd_start,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             busy,
  output logic             done,
  output logic             err_busy,
  output logic             idx_valid,
  output logic [IDX_W-1:0] idx
);
  logic accept;
  logic run;
  logic last;

  seq_issue_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_issue (cmd_issue),
    .busy      (run),
    .accept    (accept),
    .err_pulse (err_busy)
  );

  seq_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .cmd_len (cmd_len),
    .busy    (run),
    .last    (last)
  );

  seq_pc #(.IDX_W(IDX_W)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .start   (cmd_start),
    .advance (run & ~last),
    .pc      (idx)
  );

  assign busy      = run;
  assign idx_valid = run;
  assign done      = last;
endmodule

// File: rtl/nano_seq_chk.sv
module nano_seq_chk #(
  parameter int IDX_W = 5,
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_issue,
  input logic [IDX_W-1:0] cmd_start,
  input logic [LEN_W-1:0] cmd_len,
  input logic             busy,
  input logic             done,
  input logic             err_busy,
  input logic             idx_valid,
  input logic [IDX_W-1:0] idx
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] exp_len;
  logic [CNT_W-1:0] sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_len <= '0;
      sent    <= '0;
    end else if (cmd_issue && !busy) begin
      exp_len <= (cmd_len == '0) ? CNT_W'(1 << LEN_W) : {1'b0, cmd_len};
      sent    <= '0;
    end else if (idx_valid) begin
      sent <= sent + CNT_W'(1);
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && !busy) |=> (busy && idx_valid && idx == $past(cmd_start)));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && !done) |=> (idx_valid && idx == IDX_W'($past(idx) + 1'b1)));

  p_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sent + CNT_W'(1) == exp_len));

  p_done_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done && !idx_valid));

  p_done_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_reject_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && busy) |=> err_busy);

  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_issue && busy)) |=> !err_busy);
endmodule

bind nano_seq_ctrl nano_seq_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_issue (cmd_issue),
  .cmd_start (cmd_start),
  .cmd_len   (cmd_len),
  .busy      (busy),
  .done      (done),
  .err_busy  (err_busy),
  .idx_valid (idx_valid),
  .idx       (idx)
);

// File: tb/tb_nano_seq_ctrl.sv
module tb_nano_seq_ctrl;
  localparam int NPE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_issue = 1'b0;
  logic [4:0] cmd_start = '0;
  logic [4:0] cmd_len = '0;
  logic       busy, done, err_busy, idx_valid;
  logic [4:0] idx;

  int checks = 0;
  int fails = 0;

  logic [15:0] store [NPE][32];

  always #2 clk = ~clk;

  nano_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .cmd_start(cmd_start),
    .cmd_len(cmd_len), .busy(busy), .done(done), .err_busy(err_busy),
    .idx_valid(idx_valid), .idx(idx)
  );

  // start in [9:5], length in [4:0]
  localparam logic [9:0] VEC [6] = '{
    {5'd0,  5'd1},
    {5'd3,  5'd4},
    {5'd30, 5'd5},
    {5'd31, 5'd1},
    {5'd10, 5'd0},
    {5'd7,  5'd31}
  };

  function automatic logic [15:0] pe_word(input int pe, input int i);
    return 16'((pe + 1) * 16'h0101 + i * 7 + pe * 3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] s, input logic [4:0] l);
    cmd_issue = 1'b1; cmd_start = s; cmd_len = l;
    @(negedge clk);
    cmd_issue = 1'b0;
  endtask

  // Called at the negedge where the first index is shown.
  task automatic follow(input int s, input int n, input int rej_k, input string tag);
    for (int k = 0; k < n; k++) begin
      int e;
      e = (s + k) % 32;
      chk(idx_valid == 1'b1, {tag, " R2/R4 valid"}, int'(idx_valid), 1);
      chk(int'(idx) == e, {tag, " R3 index"}, int'(idx), e);
      chk(done == (k == n - 1), {tag, " R5 done"}, int'(done), int'(k == n - 1));
      for (int p = 0; p < NPE; p++)
        chk(store[p][idx] == pe_word(p, e), {tag, " R8 element fetch"},
            int'(store[p][idx]), int'(pe_word(p, e)));
      if (k == rej_k) begin
        cmd_issue = 1'b1; cmd_start = 5'(s + 13); cmd_len = 5'd2;
      end
      @(negedge clk);
      cmd_issue = 1'b0;
      if (k == rej_k)
        chk(err_busy == 1'b1, {tag, " R6 err pulse"}, int'(err_busy), 1);
      else
        chk(err_busy == 1'b0, {tag, " R6 no err"}, int'(err_busy), 0);
    end
    chk(busy == 1'b0 && idx_valid == 1'b0 && done == 1'b0, {tag, " R5 idle after"},
        int'({busy, idx_valid, done}), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < NPE; p++)
      for (int i = 0; i < 32; i++) store[p][i] = pe_word(p, i);

    repeat (3) @(negedge clk);
    chk({busy, done, err_busy, idx_valid} == 4'b0, "R1 reset flags",
        int'({busy, done, err_busy, idx_valid}), 0);
    chk(idx == 5'd0, "R1 reset index", int'(idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 idle without command", int'(busy), 0);

    for (int v = 0; v < 6; v++) begin
      int s, n;
      s = int'(VEC[v][9:5]);
      n = (VEC[v][4:0] == 5'd0) ? 32 : int'(VEC[v][4:0]);
      issue(VEC[v][9:5], VEC[v][4:0]);
      follow(s, n, -1, "table");
      @(negedge clk);
    end

    // R6: command in the middle of a run is dropped
    issue(5'd20, 5'd6);
    follow(20, 6, 2, "mid-run reject");
    @(negedge clk);

    // R6: command in the done cycle is dropped; R7: next cycle accepted
    issue(5'd28, 5'd3);
    follow(28, 3, 2, "done-cycle reject");
    issue(5'd5, 5'd2);
    follow(5, 2, -1, "R7 back-to-back");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule